// File: doc/BRIEF.md
# Data-Acquisition Card Register Interface

This block is the bus-side register logic of a multichannel analog and digital I/O card on an 8-bit I/O bus. It decodes a 16-byte I/O window. It holds the analog-input multiplexer setting and the gain code, and a control byte that selects how conversions are triggered. The trigger can come from a software write, from an external pacer tick, or be disabled. A behavioural ADC stub is run for a fixed number of cycles, and the result is presented as two bytes. Completion is reported through an active-low data-ready bit, and also through an interrupt request or a DMA request, depending on the trigger mode.

The same window also latches the 12-bit DAC codes and the 16-bit digital output word, and returns the 16-bit digital input. Some writes are strobes: any written value starts a software conversion or clears the completion flags. Pacer timing, DMA transfer and analog settling are outside the block. The pacer reaches it as a one-cycle tick, and the converter reaches it as a sample bus that is captured at the end of conversion.

Top module: `daq_regif`

## Requirements
- R1: After reset, trig_mode, irq_line, gain_code, mux_chan, mux_cs, every DAC code and do_pins are 0, irq_req and dma_req are 0, and no result is ready. The status byte at offset 0x08 reads 0x20, and in the 12-bit configuration the AI high byte at 0x05 reads 0x10.
- R2: DAC channel n takes its low byte from a write to offset 0x04+2n and its high byte from a write to 0x05+2n, keeping only bits [3:0] of the high byte. Its code dac_code[12n+11:12n] = {high[3:0], low}.
- R3: Writes to 0x0D and 0x0E set do_pins[7:0] and do_pins[15:8]. Reads of 0x06 and 0x07 return di_pins[7:0] and di_pins[15:8].
- R4: A write to 0x09 sets gain_code to the full byte. A write to 0x0A sets mux_chan from bits [3:0], mux_cs[0] from bit 4 and mux_cs[1] from bit 5.
- R5: A write to 0x0B sets trig_mode from bits [2:0] and irq_line from bits [7:4]. Both hold until the next control write. The mode codes are: 0 off, 1 software, 2 pacer with DMA request, 6 pacer with interrupt.
- R6: A write of any value to 0x0C starts a conversion only when trig_mode is 1. In every other mode the write has no effect.
- R7: pacer_tick starts a conversion only when trig_mode is 2 or 6. Codes 0, 1, 3, 4, 5 and 7 ignore it.
- R8: An accepted trigger at clock edge k drives adc_start high for the single cycle after edge k. The result is captured from adc_result at edge k+CONV_CYCLES. Triggers that arrive before that edge, or at that edge itself, are ignored.
- R9: The captured result is masked to ADC_BITS. Offset 0x04 reads bits [7:0]. Offset 0x05 reads {3'b000, ready_n, result[11:8]} with 12-bit data, or result[15:8] with 16-bit data.
- R10: Any completed conversion, whatever the mode, sets the flag. While the flag is set, status offset 0x08 reads 0x00. When the flag is clear it reads 0x20, so bit 5 is the active-low ready bit and all other bits are 0.
- R11: A completion while trig_mode is 6 raises irq_req. A write of any value to 0x08 clears irq_req and the ready flag. That write wins over a completion in the same cycle.
- R12: A completion while trig_mode is 2 raises dma_req and not irq_req. dma_req holds until a read of offset 0x04; a completion in the same cycle as that read wins.
- R13: Offsets 0x00–0x03 and 0x09–0x0F read as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Offset inside the I/O window |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 8 | Read data for bus_addr |
| pacer_tick | input | 1 | One-cycle pacer event |
| adc_result | input | 16 | Converter sample, captured at end of conversion |
| di_pins | input | 16 | Digital input pins |
| adc_start | output | 1 | Conversion start pulse to the converter |
| irq_req | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |
| mux_chan | output | 4 | Analog multiplexer channel |
| mux_cs | output | 2 | Multiplexer chip selects |
| gain_code | output | 8 | Analog gain code |
| trig_mode | output | 3 | Current trigger mode |
| irq_line | output | 4 | Selected interrupt line number |
| dac_code | output | NUM_DAC*12 | Packed DAC codes, channel 0 in the low bits |
| do_pins | output | 16 | Digital output pins |

## Verification
The conversion path is driven by software strobes and by pacer ticks in every trigger mode, including the undefined mode codes. This shows that a trigger starts a conversion only when its mode allows it. Second triggers are sent into the busy window to tell an ignored trigger apart from a restart. A status-clear write is placed on exactly the completion edge to show which of the two wins. In pacer-DMA mode, dma_req is held across idle cycles and then read away through the AI low byte, which shows that the request is released by the read and not by time. A reference model tracks every output and the read data each cycle, so register writes with distinct byte patterns also show whether the byte lanes or the high-nibble mask are mixed up.

// File: rtl/daq_regif_pkg.sv
// Package: offsets of the I/O window, trigger-mode codes and the decoded
// strobe bundle shared by the register interface modules.
package daq_regif_pkg;

    localparam logic [3:0] OFS_AI_LO  = 4'h4;
    localparam logic [3:0] OFS_AI_HI  = 4'h5;
    localparam logic [3:0] OFS_DI_LO  = 4'h6;
    localparam logic [3:0] OFS_DI_HI  = 4'h7;
    localparam logic [3:0] OFS_STATUS = 4'h8;
    localparam logic [3:0] OFS_GAIN   = 4'h9;
    localparam logic [3:0] OFS_MUX    = 4'hA;
    localparam logic [3:0] OFS_CTRL   = 4'hB;
    localparam logic [3:0] OFS_SOFT   = 4'hC;
    localparam logic [3:0] OFS_DO_LO  = 4'hD;
    localparam logic [3:0] OFS_DO_HI  = 4'hE;
    localparam logic [3:0] DAC_BASE   = 4'h4;

    localparam logic [2:0] TM_OFF      = 3'd0;
    localparam logic [2:0] TM_SOFT     = 3'd1;
    localparam logic [2:0] TM_PACE_DMA = 3'd2;
    localparam logic [2:0] TM_PACE_IRQ = 3'd6;

    localparam int DAC_BITS = 12;

    typedef struct packed {
        logic status_wr;
        logic gain_wr;
        logic mux_wr;
        logic ctrl_wr;
        logic soft_wr;
        logic do_lo_wr;
        logic do_hi_wr;
        logic ai_lo_rd;
    } strobe_t;

endpackage

// File: rtl/daq_addr_dec.sv
// Address decoder: turns the bus offset and the read/write strobes into one
// strobe per register action. Assumes one-cycle bus_wr / bus_rd pulses.
module daq_addr_dec
    import daq_regif_pkg::*;
(
    input  logic [3:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    output strobe_t    strb
);

    // Purpose: compare the offset against each register location.
    always_comb begin
        strb           = '0;
        strb.status_wr = bus_wr && (bus_addr == OFS_STATUS);
        strb.gain_wr   = bus_wr && (bus_addr == OFS_GAIN);
        strb.mux_wr    = bus_wr && (bus_addr == OFS_MUX);
        strb.ctrl_wr   = bus_wr && (bus_addr == OFS_CTRL);
        strb.soft_wr   = bus_wr && (bus_addr == OFS_SOFT);
        strb.do_lo_wr  = bus_wr && (bus_addr == OFS_DO_LO);
        strb.do_hi_wr  = bus_wr && (bus_addr == OFS_DO_HI);
        strb.ai_lo_rd  = bus_rd && (bus_addr == OFS_AI_LO);
    end

endmodule

// File: rtl/daq_conv_seq.sv
// Conversion sequencer: on an accepted trigger it stays busy for CONV_CYCLES
// clock edges, pulses start in the first busy cycle and flags done in the
// last. Triggers while busy are dropped. Assumes CONV_CYCLES >= 2.
module daq_conv_seq #(
    parameter int CONV_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic busy,
    output logic start_pulse,
    output logic done
);

    localparam int CW = (CONV_CYCLES > 2) ? $clog2(CONV_CYCLES) : 1;
    localparam logic [CW-1:0] CNT_LOAD = CW'(CONV_CYCLES - 1);

    logic [CW-1:0] cnt;

    // Purpose: load the countdown on a trigger, count it down while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end else if (trig) begin
            busy <= 1'b1;
            cnt  <= CNT_LOAD;
        end
    end

    assign done        = busy && (cnt == '0);
    assign start_pulse = busy && (cnt == CNT_LOAD);

endmodule

// File: rtl/daq_dac_bank.sv
// DAC code latches: one low/high byte pair per channel at offsets
// DAC_BASE+2n / DAC_BASE+2n+1; only the high nibble's low four bits kept.
module daq_dac_bank
    import daq_regif_pkg::*;
#(
    parameter int NUM_DAC = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_wr,
    input  logic [3:0]                  bus_addr,
    input  logic [7:0]                  bus_wdata,
    output logic [NUM_DAC*DAC_BITS-1:0] dac_code
);

    for (genvar n = 0; n < NUM_DAC; n++) begin : g_ch
        localparam logic [3:0] LO_OFS = DAC_BASE + 4'(2 * n);
        localparam logic [3:0] HI_OFS = DAC_BASE + 4'(2 * n + 1);

        logic [7:0] lo_q;
        logic [3:0] hi_q;

        // Purpose: latch this channel's byte lanes on their own offsets.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lo_q <= '0;
                hi_q <= '0;
            end else if (bus_wr) begin
                if (bus_addr == LO_OFS) lo_q <= bus_wdata;
                if (bus_addr == HI_OFS) hi_q <= bus_wdata[3:0];
            end
        end

        assign dac_code[n*DAC_BITS +: DAC_BITS] = {hi_q, lo_q};
    end

endmodule

// File: rtl/daq_regif.sv
// Register interface of the acquisition card: control/mux/gain/DO storage,
// trigger qualification, result capture, ready flag, IRQ and DMA requests,
// and the read-back multiplexer. Assumes ADC_BITS is 12 or 16.
module daq_regif
    import daq_regif_pkg::*;
#(
    parameter int ADC_BITS    = 12,
    parameter int CONV_CYCLES = 8,
    parameter int NUM_DAC     = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [3:0]              bus_addr,
    input  logic                    bus_wr,
    input  logic [7:0]              bus_wdata,
    input  logic                    bus_rd,
    output logic [7:0]              bus_rdata,
    input  logic                    pacer_tick,
    input  logic [15:0]             adc_result,
    input  logic [15:0]             di_pins,
    output logic                    adc_start,
    output logic                    irq_req,
    output logic                    dma_req,
    output logic [3:0]              mux_chan,
    output logic [1:0]              mux_cs,
    output logic [7:0]              gain_code,
    output logic [2:0]              trig_mode,
    output logic [3:0]              irq_line,
    output logic [NUM_DAC*12-1:0]   dac_code,
    output logic [15:0]             do_pins
);

    localparam logic [15:0] RES_MASK = 16'((32'd1 << ADC_BITS) - 1);
    localparam bit          WIDE_ADC = (ADC_BITS > 12);

    strobe_t     strb;
    logic        conv_busy;
    logic        conv_done;
    logic        trig_ok;
    logic        eoc_q;
    logic [15:0] res_q;
    logic [7:0]  ai_hi_byte;

    daq_addr_dec u_dec (
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .strb     (strb)
    );

    daq_dac_bank #(.NUM_DAC(NUM_DAC)) u_dac (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .dac_code  (dac_code)
    );

    // Purpose: qualify software strobes and pacer ticks by the trigger mode.
    always_comb begin
        unique case (trig_mode)
            TM_SOFT:                  trig_ok = strb.soft_wr;
            TM_PACE_DMA, TM_PACE_IRQ: trig_ok = pacer_tick;
            default:                  trig_ok = 1'b0;
        endcase
    end

    daq_conv_seq #(.CONV_CYCLES(CONV_CYCLES)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig        (trig_ok),
        .busy        (conv_busy),
        .start_pulse (adc_start),
        .done        (conv_done)
    );

    // Purpose: hold the control, mux, gain and digital-output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_mode <= TM_OFF;
            irq_line  <= '0;
            mux_chan  <= '0;
            mux_cs    <= '0;
            gain_code <= '0;
            do_pins   <= '0;
        end else begin
            if (strb.ctrl_wr) begin
                trig_mode <= bus_wdata[2:0];
                irq_line  <= bus_wdata[7:4];
            end
            if (strb.mux_wr) begin
                mux_chan <= bus_wdata[3:0];
                mux_cs   <= bus_wdata[5:4];
            end
            if (strb.gain_wr)  gain_code     <= bus_wdata;
            if (strb.do_lo_wr) do_pins[7:0]  <= bus_wdata;
            if (strb.do_hi_wr) do_pins[15:8] <= bus_wdata;
        end
    end

    // Purpose: capture the masked converter sample at end of conversion.
    always_ff @(posedge clk) begin
        if (!rst_n)         res_q <= '0;
        else if (conv_done) res_q <= adc_result & RES_MASK;
    end

    // Purpose: ready flag and interrupt; a status write beats a completion.
    always_ff @(posedge clk) begin
        if (!rst_n || strb.status_wr) begin
            eoc_q   <= 1'b0;
            irq_req <= 1'b0;
        end else if (conv_done) begin
            eoc_q <= 1'b1;
            if (trig_mode == TM_PACE_IRQ) irq_req <= 1'b1;
        end
    end

    // Purpose: DMA request set by a pacer-DMA completion, dropped by AI low read.
    always_ff @(posedge clk) begin
        if (!rst_n)                                        dma_req <= 1'b0;
        else if (conv_done && (trig_mode == TM_PACE_DMA)) dma_req <= 1'b1;
        else if (strb.ai_lo_rd)                            dma_req <= 1'b0;
    end

    // Purpose: pick the AI high byte layout for the converter width.
    generate
        if (WIDE_ADC) begin : g_wide
            assign ai_hi_byte = res_q[15:8];
        end else begin : g_narrow
            assign ai_hi_byte = {3'b000, ~eoc_q, res_q[11:8]};
        end
    endgenerate

    // Purpose: read-back multiplexer; write-only offsets return zero.
    always_comb begin
        unique case (bus_addr)
            OFS_AI_LO:  bus_rdata = res_q[7:0];
            OFS_AI_HI:  bus_rdata = ai_hi_byte;
            OFS_DI_LO:  bus_rdata = di_pins[7:0];
            OFS_DI_HI:  bus_rdata = di_pins[15:8];
            OFS_STATUS: bus_rdata = {2'b00, ~eoc_q, 5'b00000};
            default:    bus_rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/daq_regif_chk.sv
// Checker: temporal properties of the register interface, bound to daq_regif.
module daq_regif_chk #(
    parameter int CONV_CYCLES = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] bus_addr,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [2:0] trig_mode,
    input logic       irq_req,
    input logic       dma_req,
    input logic       adc_start
);

    logic [31:0] gap_cnt;

    // Purpose: count the cycles since the last start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)         gap_cnt <= '0;
        else if (adc_start) gap_cnt <= 32'(CONV_CYCLES);
        else if (gap_cnt != 0) gap_cnt <= gap_cnt - 1;
    end

    // R8: no new start while a conversion is still running
    a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> (gap_cnt == 0));

    // R11: an interrupt only rises out of pacer-interrupt mode
    a_r11_irq_mode: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> ($past(trig_mode) == 3'd6));

    // R11: a status write leaves the interrupt low
    a_r11_status_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 4'h8) |=> !irq_req);

    // R12: a DMA request only rises out of pacer-DMA mode
    a_r12_dma_mode: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_req) |-> ($past(trig_mode) == 3'd2));

    // R12: the DMA request holds until the AI low byte is read
    a_r12_dma_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && !(bus_rd && bus_addr == 4'h4)) |=> dma_req);

endmodule

bind daq_regif daq_regif_chk #(.CONV_CYCLES(CONV_CYCLES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .trig_mode (trig_mode),
    .irq_req   (irq_req),
    .dma_req   (dma_req),
    .adc_start (adc_start)
);

// File: tb/tb_daq_regif.sv
// Bench: behavioural reference model updated on every rising edge and
// compared with every DUT output on every falling edge.
module tb_daq_regif;

    localparam int CLK_PERIOD = 10;
    localparam int CONV       = 8;
    localparam int NDAC       = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic        pacer_tick = 1'b0;
    logic [15:0] adc_result = '0;
    logic [15:0] di_pins = '0;
    logic        adc_start, irq_req, dma_req;
    logic [3:0]  mux_chan;
    logic [1:0]  mux_cs;
    logic [7:0]  gain_code;
    logic [2:0]  trig_mode;
    logic [3:0]  irq_line;
    logic [NDAC*12-1:0] dac_code;
    logic [15:0] do_pins;

    int vectors = 0;
    int miscompares = 0;

    daq_regif #(.ADC_BITS(12), .CONV_CYCLES(CONV), .NUM_DAC(NDAC)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pacer_tick(pacer_tick), .adc_result(adc_result), .di_pins(di_pins),
        .adc_start(adc_start), .irq_req(irq_req), .dma_req(dma_req),
        .mux_chan(mux_chan), .mux_cs(mux_cs), .gain_code(gain_code),
        .trig_mode(trig_mode), .irq_line(irq_line), .dac_code(dac_code),
        .do_pins(do_pins)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // reference model state
    int m_mode, m_line, m_chan, m_cs, m_gain, m_do, m_res, m_busy;
    int m_eoc, m_irq, m_dma;
    int m_dlo[NDAC];
    int m_dhi[NDAC];

    function automatic int model_rd(input int a);
        case (a)
            4: return m_res & 8'hFF;
            5: return ((m_eoc != 0) ? 0 : 8'h10) | ((m_res >> 8) & 4'hF);
            6: return di_pins[7:0];
            7: return di_pins[15:8];
            8: return (m_eoc != 0) ? 8'h00 : 8'h20;
            default: return 0;
        endcase
    endfunction

    function automatic string rd_tag(input int a);
        case (a)
            4, 5: return "R9";
            6, 7: return "R3";
            8:    return "R10";
            default: return "R13";
        endcase
    endfunction

    // Model update: behaves on the inputs seen at this rising edge.
    always @(posedge clk) begin
        int  om;
        bit  done, trig;
        if (!rst_n) begin
            m_mode = 0; m_line = 0; m_chan = 0; m_cs = 0; m_gain = 0; m_do = 0;
            m_res = 0; m_busy = 0; m_eoc = 0; m_irq = 0; m_dma = 0;
            foreach (m_dlo[i]) begin m_dlo[i] = 0; m_dhi[i] = 0; end
        end else begin
            om   = m_mode;
            done = (m_busy == 1);
            trig = (m_busy == 0) &&
                   ((om == 1 && bus_wr && bus_addr == 12) ||
                    ((om == 2 || om == 6) && pacer_tick));
            if (m_busy > 0) m_busy = m_busy - 1;
            if (trig) m_busy = CONV;
            if (done) m_res = adc_result & 16'h0FFF;
            if (bus_wr && bus_addr == 8) begin
                m_eoc = 0; m_irq = 0;
            end else if (done) begin
                m_eoc = 1;
                if (om == 6) m_irq = 1;
            end
            if (done && om == 2) m_dma = 1;
            else if (bus_rd && bus_addr == 4) m_dma = 0;
            if (bus_wr) begin
                for (int n = 0; n < NDAC; n++) begin
                    if (bus_addr == 4 + 2*n) m_dlo[n] = bus_wdata;
                    if (bus_addr == 5 + 2*n) m_dhi[n] = bus_wdata & 8'h0F;
                end
                case (bus_addr)
                    9:  m_gain = bus_wdata;
                    10: begin m_chan = bus_wdata & 4'hF; m_cs = (bus_wdata >> 4) & 2'h3; end
                    11: begin m_mode = bus_wdata & 3'h7; m_line = bus_wdata >> 4; end
                    13: m_do = (m_do & 16'hFF00) | bus_wdata;
                    14: m_do = (m_do & 16'h00FF) | (bus_wdata << 8);
                    default: ;
                endcase
            end
        end
    end

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison of every output against the model.
    always @(negedge clk) begin
        if (rst_n) begin
            cmp("R5", "trig_mode", trig_mode, m_mode);
            cmp("R5", "irq_line", irq_line, m_line);
            cmp("R4", "mux_chan", mux_chan, m_chan);
            cmp("R4", "mux_cs", mux_cs, m_cs);
            cmp("R4", "gain_code", gain_code, m_gain);
            cmp("R3", "do_pins", do_pins, m_do);
            for (int n = 0; n < NDAC; n++)
                cmp("R2", "dac_code", dac_code[n*12 +: 12], (m_dhi[n] << 8) | m_dlo[n]);
            cmp("R8", "adc_start", adc_start, (m_busy == CONV) ? 1 : 0);
            cmp("R11", "irq_req", irq_req, m_irq);
            cmp("R12", "dma_req", dma_req, m_dma);
            cmp(rd_tag(bus_addr), "bus_rdata", bus_rdata, model_rd(bus_addr));
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input string tag);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        cmp(tag, "read", bus_rdata, model_rd(a));
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic tick();
        pacer_tick = 1'b1;
        @(posedge clk); #1;
        pacer_tick = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        di_pins = 16'h5AA5;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        cmp("R1", "dac_code", dac_code, 0);
        cmp("R1", "trig_mode", trig_mode, 0);
        cmp("R1", "do_pins", do_pins, 0);
        rd_chk(4'h8, "R1");
        cmp("R1", "status", bus_rdata, 8'h20);
        rd_chk(4'h5, "R1");
        // R2: DAC byte lanes and high-nibble mask
        wr(4'h4, 8'h34); wr(4'h5, 8'hF2);
        wr(4'h6, 8'hAB); wr(4'h7, 8'h1C);
        cmp("R2", "dac0", dac_code[11:0], 12'h234);
        cmp("R2", "dac1", dac_code[23:12], 12'hCAB);
        // R3: digital in/out
        rd_chk(4'h6, "R3"); rd_chk(4'h7, "R3");
        wr(4'hD, 8'h5A); wr(4'hE, 8'hC3);
        cmp("R3", "do_pins", do_pins, 16'hC35A);
        // R4: gain and mux
        wr(4'h9, 8'h07); wr(4'hA, 8'h3F);
        cmp("R4", "mux_cs", mux_cs, 2'b11);
        // R13: write-only and unmapped offsets read zero
        rd_chk(4'h9, "R13"); rd_chk(4'hA, "R13"); rd_chk(4'h0, "R13"); rd_chk(4'hF, "R13");
        // R5: control byte
        wr(4'hB, 8'h51);
        cmp("R5", "irq_line", irq_line, 4'h5);
        // R7: pacer ignored in software mode
        adc_result = 16'hABCD;
        tick(); idle(CONV + 2);
        rd_chk(4'h8, "R7");
        // R6/R8: software start, second strobe while busy dropped
        wr(4'hC, 8'h00); wr(4'hC, 8'hFF);
        idle(CONV + 2);
        // R9: masked result bytes
        rd_chk(4'h5, "R9"); rd_chk(4'h4, "R9");
        rd_chk(4'h8, "R10");
        cmp("R11", "irq_req", irq_req, 0);
        wr(4'h8, 8'h77);
        rd_chk(4'h8, "R10");
        // R6: software strobe ignored when disabled
        wr(4'hB, 8'h50); wr(4'hC, 8'h00); idle(CONV + 2);
        rd_chk(4'h8, "R6");
        // R7: undefined mode ignores pacer
        wr(4'hB, 8'h53); tick(); idle(CONV + 2);
        rd_chk(4'h8, "R7");
        // R11: pacer with interrupt
        wr(4'hB, 8'h66); adc_result = 16'h1234;
        tick(); idle(CONV + 2);
        cmp("R11", "irq_req", irq_req, 1);
        rd_chk(4'h4, "R9");
        wr(4'h8, 8'h00);
        cmp("R11", "irq_req", irq_req, 0);
        // R11: status write on the completion edge wins
        tick(); idle(CONV - 1);
        wr(4'h8, 8'h00);
        cmp("R11", "irq_req", irq_req, 0);
        rd_chk(4'h8, "R11");
        // R12: pacer with DMA request, held until AI low read
        wr(4'hB, 8'h62); adc_result = 16'hFFFF;
        tick(); idle(3); tick(); idle(CONV);
        cmp("R12", "dma_req", dma_req, 1);
        cmp("R12", "irq_req", irq_req, 0);
        idle(5);
        cmp("R12", "dma_req", dma_req, 1);
        rd_chk(4'h4, "R12");
        cmp("R12", "dma_req", dma_req, 0);
        idle(3);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule